// File: doc/BRIEF.md
# OSD Sync and Blanking Output Conditioner

This block sits between the raw flyback inputs of an on-screen-display engine and the rest of the display pipeline. It brings the horizontal and vertical flyback signals into the pixel-clock domain and turns each one into an active-high pulse, whatever polarity the monitor delivers. It also drives the fast-blank output that keys the overlay into the video path, and a shared auxiliary pin. That pin carries either the half-tone flag or a 50% duty clock. The clock is derived from the pixel clock and kept in phase with the line.

Software programs the block through a plain address/data/write-enable port into two byte registers. The main configuration register picks the sync polarities, the fast-blank polarity, the auxiliary pin source and the clock divide band. It also holds the bits for the edge-distortion detector enable and the test mode. Both of these are passed out to neighbouring logic. A second register holds the fast-blank gating source.

Top module: `osd_sync_cond`

## Requirements
- R1: While reset is held, and until the first write, the configuration register is 0x40. So `fblank_out`, `hsync_out`, `vsync_out`, `vco_band`, `edge_chk_en` and `test_mode` are all 0, and `aux_out` follows `halftone`. The gating register is 0.
- R2: A write takes effect only when `cfg_we` is 1 and `cfg_addr` equals CFG_ADDR (default 18) or MODE_ADDR (default 17). A write to any other address leaves every output unchanged.
- R3: Configuration bit 3 selects the horizontal sync polarity. At 1, `hsync_out` equals `hflb_in`. At 0, it equals the inverse of `hflb_in`. The input reaches `hsync_out` after three pixel-clock edges.
- R4: Configuration bit 2 selects the vertical sync polarity in the same way. `vsync_out` follows `vflb_in` with the same three-edge latency.
- R5: Configuration bit 6 sets the fast-blank polarity. At 1, `fblank_out` is high while blanking is active. At 0, it is low while blanking is active.
- R6: Bit 0 of the gating register selects the blanking source. At 0, blanking is active while `char_active` or `window_active` is high. At 1, blanking is active only while `char_active` is high. `fblank_out` is registered and lags its inputs by one edge.
- R7: Configuration bit 5 at 0 makes `aux_out` follow `halftone` without delay. At 1, `aux_out` carries the divided clock.
- R8: The divided clock has a 50% duty cycle. Its half period is BASE_HALF shifted left by the band field, configuration bits 1:0. With the default BASE_HALF of 2, the half period is 2, 4, 8 or 16 cycles.
- R9: The clock divider restarts on each rising edge of `hsync_out`. Starting one cycle after that edge, the clock is high for one half period and then low for one half period.
- R10: `vco_band` equals configuration bits 1:0, `edge_chk_en` equals bit 4, and `test_mode` equals bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hflb_in | input | 1 | Raw horizontal flyback, either polarity |
| vflb_in | input | 1 | Raw vertical flyback, either polarity |
| char_active | input | 1 | A character pixel is being displayed |
| window_active | input | 1 | A background window is being displayed |
| halftone | input | 1 | Half-tone flag from the display engine |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address |
| cfg_wdata | input | 8 | Register write data |
| hsync_out | output | 1 | Active-high horizontal sync in the pixel domain |
| vsync_out | output | 1 | Active-high vertical sync in the pixel domain |
| fblank_out | output | 1 | Fast-blank output, polarity as programmed |
| aux_out | output | 1 | Half-tone or line-locked divided clock |
| vco_band | output | 2 | Pixel-rate band for the clock generator |
| edge_chk_en | output | 1 | Enable for the sync edge-distortion detector |
| test_mode | output | 1 | Test mode bit; 0 in normal use |

## Verification
The bench times sync propagation to the exact edge. A design with one synchroniser stage too few or too many shows the change a cycle early or late. A design that inverts the wrong polarity fails as soon as bit 3 or bit 2 is cleared. The bench restarts the line at an offset that leaves the divider mid-phase. This catches a divider that free-runs instead of locking to the sync edge: its high run is cut short. The bench also checks run lengths in two bands, which exposes an off-by-one in the half period. Finally, it writes to a neighbouring address and then swaps the gating source. These steps catch a loose address decode and a source mux with its two sides swapped.

// File: rtl/osd_sync_pkg.sv
// Shared types for the OSD sync conditioner.
// Assumes the configuration byte layout below is fixed by software.
package osd_sync_pkg;

    // Main configuration byte, b7 down to b0.
    typedef struct packed {
        logic       test;        // b7 test mode, 0 in normal use
        logic       fb_pol;      // b6 fast-blank active-high when 1
        logic       aux_clk_sel; // b5 divided clock on aux pin when 1
        logic       edge_chk;    // b4 edge-distortion detector enable
        logic       hs_pol;      // b3 accept positive hsync when 1
        logic       vs_pol;      // b2 accept positive vsync when 1
        logic [1:0] band;        // b1:b0 pixel-rate band
    } osd_cfg_t;

    localparam logic [7:0] CFG_RESET = 8'h40;
    localparam int         NUM_SYNC  = 2;
    localparam int         SYNC_H    = 0;
    localparam int         SYNC_V    = 1;

endpackage

// File: rtl/osd_cfg_reg.sv
// Holds the main configuration byte and the blanking gate register.
// Assumes writes are single-cycle strobes in the pixel-clock domain.
module osd_cfg_reg
    import osd_sync_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int CFG_ADDR  = 18,
    parameter int MODE_ADDR = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output osd_cfg_t          cfg,
    output logic              char_only
);
    localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(CFG_ADDR);
    localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_ADDR);

    // Main configuration byte: load on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= osd_cfg_t'(CFG_RESET);
        else if (we && addr == CFG_A)
            cfg <= osd_cfg_t'(wdata);
    end

    // Gate register: bit 0 picks the blanking source.
    always_ff @(posedge clk) begin
        if (!rst_n)
            char_only <= 1'b0;
        else if (we && addr == MODE_A)
            char_only <= wdata[0];
    end

    logic unused_hi;
    assign unused_hi = ^wdata[7:1];
endmodule

// File: rtl/osd_sync_norm.sv
// Brings N raw sync inputs into the pixel domain with a two-flop
// synchroniser, then converts each to active-high with a registered
// polarity correction. The latency is three edges.
module osd_sync_norm #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    input  logic [N-1:0] pos_pol,
    output logic [N-1:0] norm
);
    for (genvar i = 0; i < N; i++) begin : g_ch
        logic meta_q, sync_q, out_q;

        // Two-stage synchroniser followed by the polarity stage.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                out_q  <= 1'b0;
            end else begin
                meta_q <= raw[i];
                sync_q <= meta_q;
                out_q  <= pos_pol[i] ? sync_q : ~sync_q;
            end
        end

        assign norm[i] = out_q;
    end
endmodule

// File: rtl/osd_fblank_gen.sv
// Fast-blank generator: picks the blanking source and applies the
// output polarity. The output is registered, one edge behind its inputs.
module osd_fblank_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic char_active,
    input  logic window_active,
    input  logic char_only,
    input  logic active_high,
    output logic fblank
);
    logic blank_on;

    // Source selection: characters only, or characters and windows.
    always_comb begin
        blank_on = char_only ? char_active : (char_active | window_active);
    end

    // Apply the output polarity and register the result.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fblank <= 1'b0;
        else
            fblank <= active_high ? blank_on : ~blank_on;
    end
endmodule

// File: rtl/osd_aux_clk.sv
// Line-locked clock divider and auxiliary pin mux. The divider restarts
// high on each rising edge of the normalised hsync. It toggles every
// (BASE_HALF << band) pixel clocks, which gives a 50% duty cycle.
module osd_aux_clk #(
    parameter int BASE_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hs_norm,
    input  logic [1:0] band,
    input  logic       clk_sel,
    input  logic       halftone,
    output logic       aux
);
    localparam int MAX_HALF = BASE_HALF << 3;
    localparam int CNT_W    = $clog2(MAX_HALF) + 1;

    logic             hs_d;
    logic             line_start;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic             div_q;

    // Half-period limit for the selected band.
    always_comb begin
        limit = CNT_W'((BASE_HALF << band) - 1);
    end

    // Delayed hsync used to find its leading edge.
    always_ff @(posedge clk) begin
        if (!rst_n) hs_d <= 1'b0;
        else        hs_d <= hs_norm;
    end

    assign line_start = hs_norm & ~hs_d;

    // Divider: restart on a line edge, otherwise count and toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            div_q <= 1'b0;
        end else if (line_start) begin
            cnt   <= '0;
            div_q <= 1'b1;
        end else if (cnt >= limit) begin
            cnt   <= '0;
            div_q <= ~div_q;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    // Shared pin mux: half-tone or divided clock.
    always_comb begin
        aux = clk_sel ? div_q : halftone;
    end
endmodule

// File: rtl/osd_sync_cond.sv
// Top level of the OSD sync and blanking conditioner. Everything runs
// on the pixel clock. The raw flyback inputs are treated as asynchronous.
module osd_sync_cond
    import osd_sync_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int CFG_ADDR  = 18,
    parameter int MODE_ADDR = 17,
    parameter int BASE_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hflb_in,
    input  logic              vflb_in,
    input  logic              char_active,
    input  logic              window_active,
    input  logic              halftone,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic              hsync_out,
    output logic              vsync_out,
    output logic              fblank_out,
    output logic              aux_out,
    output logic [1:0]        vco_band,
    output logic              edge_chk_en,
    output logic              test_mode
);
    osd_cfg_t              cfg_q;
    logic                  char_only_q;
    logic [NUM_SYNC-1:0]   sync_raw;
    logic [NUM_SYNC-1:0]   sync_pol;
    logic [NUM_SYNC-1:0]   sync_norm;

    osd_cfg_reg #(
        .ADDR_W   (ADDR_W),
        .CFG_ADDR (CFG_ADDR),
        .MODE_ADDR(MODE_ADDR)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .cfg      (cfg_q),
        .char_only(char_only_q)
    );

    assign sync_raw[SYNC_H] = hflb_in;
    assign sync_raw[SYNC_V] = vflb_in;
    assign sync_pol[SYNC_H] = cfg_q.hs_pol;
    assign sync_pol[SYNC_V] = cfg_q.vs_pol;

    osd_sync_norm #(.N(NUM_SYNC)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (sync_raw),
        .pos_pol(sync_pol),
        .norm   (sync_norm)
    );

    osd_fblank_gen u_fb (
        .clk          (clk),
        .rst_n        (rst_n),
        .char_active  (char_active),
        .window_active(window_active),
        .char_only    (char_only_q),
        .active_high  (cfg_q.fb_pol),
        .fblank       (fblank_out)
    );

    osd_aux_clk #(.BASE_HALF(BASE_HALF)) u_aux (
        .clk     (clk),
        .rst_n   (rst_n),
        .hs_norm (sync_norm[SYNC_H]),
        .band    (cfg_q.band),
        .clk_sel (cfg_q.aux_clk_sel),
        .halftone(halftone),
        .aux     (aux_out)
    );

    assign hsync_out   = sync_norm[SYNC_H];
    assign vsync_out   = sync_norm[SYNC_V];
    assign vco_band    = cfg_q.band;
    assign edge_chk_en = cfg_q.edge_chk;
    assign test_mode   = cfg_q.test;
endmodule

// File: rtl/osd_sync_cond_chk.sv
// Property checker for osd_sync_cond, attached with bind. It watches
// the ports and the two configuration registers.
module osd_sync_cond_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hflb_in,
    input logic       vflb_in,
    input logic       char_active,
    input logic       window_active,
    input logic       halftone,
    input logic       cfg_we,
    input logic       hsync_out,
    input logic       vsync_out,
    input logic       fblank_out,
    input logic       aux_out,
    input logic [1:0] vco_band,
    input logic       edge_chk_en,
    input logic       test_mode,
    input logic [7:0] cfg_bits,
    input logic       gate_char
);
    logic [2:0] since_rst;

    // Cycles since reset, saturating, to guard the three-deep history.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 1'b1;
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_we) |-> ($stable(vco_band) && $stable(edge_chk_en) && $stable(test_mode))); // R2

    AST_HSYNC_POL: assert property (@(posedge clk) disable iff (!rst_n)
        since_rst >= 3'd4 |-> hsync_out == ($past(cfg_bits[3]) ? $past(hflb_in, 3) : !$past(hflb_in, 3))); // R3

    AST_VSYNC_POL: assert property (@(posedge clk) disable iff (!rst_n)
        since_rst >= 3'd4 |-> vsync_out == ($past(cfg_bits[2]) ? $past(vflb_in, 3) : !$past(vflb_in, 3))); // R4

    AST_FBLANK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        since_rst >= 3'd1 |-> fblank_out == ($past(cfg_bits[6]) ==
            ($past(gate_char) ? $past(char_active) : ($past(char_active) || $past(window_active))))); // R5

    AST_AUX_HALFTONE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_bits[5] |-> aux_out == halftone); // R7

    AST_LINE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync_out) |=> (!cfg_bits[5] || aux_out)); // R9
endmodule

bind osd_sync_cond osd_sync_cond_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hflb_in      (hflb_in),
    .vflb_in      (vflb_in),
    .char_active  (char_active),
    .window_active(window_active),
    .halftone     (halftone),
    .cfg_we       (cfg_we),
    .hsync_out    (hsync_out),
    .vsync_out    (vsync_out),
    .fblank_out   (fblank_out),
    .aux_out      (aux_out),
    .vco_band     (vco_band),
    .edge_chk_en  (edge_chk_en),
    .test_mode    (test_mode),
    .cfg_bits     (cfg_q),
    .gate_char    (char_only_q)
);

// File: tb/osd_sync_cond_test.sv
// Directed bench for osd_sync_cond: one task per scenario.
module osd_sync_cond_test;
    localparam int ADDR_W = 5;
    localparam int BASE_HALF = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hflb_in = 1'b0, vflb_in = 1'b0;
    logic char_active = 1'b0, window_active = 1'b0, halftone = 1'b0;
    logic cfg_we = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic hsync_out, vsync_out, fblank_out, aux_out, edge_chk_en, test_mode;
    logic [1:0] vco_band;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    osd_sync_cond uut (
        .clk(clk), .rst_n(rst_n), .hflb_in(hflb_in), .vflb_in(vflb_in),
        .char_active(char_active), .window_active(window_active),
        .halftone(halftone), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .hsync_out(hsync_out), .vsync_out(vsync_out),
        .fblank_out(fblank_out), .aux_out(aux_out), .vco_band(vco_band),
        .edge_chk_en(edge_chk_en), .test_mode(test_mode)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        halftone = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 hsync", {7'd0, hsync_out}, 8'd0);
        check("R1 vsync", {7'd0, vsync_out}, 8'd0);
        check("R1 fblank", {7'd0, fblank_out}, 8'd0);
        check("R1 aux", {7'd0, aux_out}, 8'd1);
        check("R1 fields", {4'd0, test_mode, edge_chk_en, vco_band}, 8'd0);
        halftone = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_decode();
        wr(5'd19, 8'b1001_0011);
        @(negedge clk);
        check("R2 ignored addr", {4'd0, test_mode, edge_chk_en, vco_band}, 8'd0);
        wr(5'd18, 8'b0101_1110);
        check("R10 fields", {4'd0, test_mode, edge_chk_en, vco_band}, 8'b0000_0110);
    endtask

    // Latency and polarity of one sync path; config bits set by caller.
    task automatic t_sync(input bit vert, input bit pos);
        string tag;
        tag = vert ? "R4" : "R3";
        if (vert) vflb_in = 1'b0; else hflb_in = 1'b0;
        repeat (5) @(negedge clk);
        if (vert) vflb_in = 1'b1; else hflb_in = 1'b1;
        repeat (2) @(negedge clk);
        check({tag, " before latency"}, {7'd0, vert ? vsync_out : hsync_out}, {7'd0, !pos});
        @(negedge clk);
        check({tag, " after latency"}, {7'd0, vert ? vsync_out : hsync_out}, {7'd0, pos});
    endtask

    task automatic t_fblank();
        wr(5'd18, 8'h40);
        wr(5'd17, 8'h00);
        char_active = 1'b0; window_active = 1'b1;
        @(negedge clk);
        check("R6 window gates", {7'd0, fblank_out}, 8'd1);
        wr(5'd17, 8'h01);
        @(negedge clk);
        check("R6 char only", {7'd0, fblank_out}, 8'd0);
        char_active = 1'b1;
        @(negedge clk);
        check("R6 char on", {7'd0, fblank_out}, 8'd1);
        wr(5'd18, 8'h00);
        @(negedge clk);
        check("R5 active low", {7'd0, fblank_out}, 8'd0);
        char_active = 1'b0;
        @(negedge clk);
        check("R5 idle high", {7'd0, fblank_out}, 8'd1);
        window_active = 1'b0;
    endtask

    task automatic t_aux_mux();
        wr(5'd18, 8'h48);
        halftone = 1'b1; #1;
        check("R7 halftone hi", {7'd0, aux_out}, 8'd1);
        halftone = 1'b0; #1;
        check("R7 halftone lo", {7'd0, aux_out}, 8'd0);
    endtask

    // Line-locked clock: restart, run lengths in band b.
    task automatic t_pwm(input logic [1:0] b, input int pre);
        int half;
        half = BASE_HALF << b;
        wr(5'd18, {6'b0110_10, b});
        hflb_in = 1'b0;
        repeat (pre) @(negedge clk);
        hflb_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 hsync seen", {7'd0, hsync_out}, 8'd1);
        for (int k = 0; k < 2 * half; k++) begin
            @(negedge clk);
            check(k < half ? "R9 R8 high phase" : "R8 low phase",
                  {7'd0, aux_out}, {7'd0, k < half});
        end
        @(negedge clk);
        check("R8 next high", {7'd0, aux_out}, 8'd1);
        hflb_in = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_decode();
        wr(5'd18, 8'h08); t_sync(1'b0, 1'b1);
        wr(5'd18, 8'h00); t_sync(1'b0, 1'b0);
        wr(5'd18, 8'h04); t_sync(1'b1, 1'b1);
        wr(5'd18, 8'h00); t_sync(1'b1, 1'b0);
        t_fblank();
        t_aux_mux();
        t_pwm(2'd0, 6);
        t_pwm(2'd2, 9);
        t_pwm(2'd1, 13);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule